// File: doc/BRIEF.md
# Gold Code Reference Sample Generator

This block builds the reference waveform that a frequency-domain correlator needs for one chosen satellite spreading code. Software or a controller first presents a code number and pulses a load strobe. That selects one of 37 phase-tap pairs on the second of two 10-stage maximal-length shift registers. A start pulse then launches one generation pass. Both registers begin from all ones. Each cycle writes one signed fixed-point sample, with an address, toward a reference memory.

Each 1023-chip code chip is written as two identical samples of +1 or -1, which gives 2046 samples per code period. The whole period is written a second time, and four zero samples then fill the frame to a 4096-point transform length. A one-cycle done pulse follows the final write. A code number outside the supported range is flagged, and no pass can be launched with it.

Top module: `gold_ref_gen`

## Requirements
- R1: The chip stream is bit 10 of register A XOR (the two selected stages of register B). Register A feeds back stages 3 and 10 (x^10+x^3+1). Register B feeds back stages 2, 3, 6, 8, 9 and 10. Stages shift from 1 toward 10, and both registers are all ones at the first chip of a pass. For code 1 the first ten chips are 1,1,0,0,1,0,0,0,0,0.
- R2: With an 8-bit sample, chip value 0 is written as +1 (0x40: sign 0, units 1, six fraction bits 0), and chip value 1 is written as -1 (0xC0).
- R3: Every chip occupies two consecutive, equal samples, so one code period fills addresses 0 to 2045.
- R4: The sample at address 2046+k equals the sample at address k, for k from 0 to 2045.
- R5: Addresses 4092 to 4095 carry the value 0.
- R6: The write enable is high for exactly 4096 consecutive cycles. It starts in the cycle after the start pulse is sampled, and the address runs 0, 1, ..., 4095, one step per cycle.
- R7: Done is high for exactly one cycle, the cycle after address 4095 is written. Busy and write enable are low in that same cycle.
- R8: Loading a code number outside 1 to 37 sets the error flag and blocks later start pulses, so no writes occur. A later valid load clears the flag.
- R9: A start pulse or a load strobe that arrives during a pass is ignored. The pass continues unchanged, and the selected code stays as it was.
- R10: Each code uses its own stage pair of register B. Code 1 uses (2,6), code 2 uses (3,7), code 5 uses (1,9) and code 24 uses (4,6). Codes 34 and 37 both use (4,10), so their outputs are identical.
- R11: After reset, write enable, busy, done and the error flag are low. A start pulse given before any code has been loaded produces no writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| code_num | input | 6 | Satellite code number, sampled on code_load |
| code_load | input | 1 | Strobe that latches code_num |
| start | input | 1 | Pulse that launches one generation pass |
| wr_en | output | 1 | Sample write enable |
| wr_addr | output | 12 | Reference memory address |
| wr_data | output | 8 | Signed sample: sign, units, six fraction bits |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | One-cycle pulse after the final write |
| code_err | output | 1 | Last loaded code number was out of range |

## Verification
The hardest case to reach is a load strobe or start pulse that lands in the middle of a pass. The bench produces it by raising both strobes at sample 100 of a running pass, with a different code number on the input. It then checks that exactly 4096 writes follow, that the captured frame matches the frame of the earlier, undisturbed pass, and that a fresh pass without any reload still produces the original code. The return of both registers to all ones after 1023 shifts is never visible at the ports. The bench covers it by comparing the second period against the first.

// File: rtl/gref_pkg.sv
package gref_pkg;
   localparam int CODE_LEN = 1023;
   localparam int NSTG     = 10;
   localparam int CNUM_W   = 6;
   localparam int TAP_W    = 4;
   localparam int CODE_MIN = 1;
   localparam int CODE_MAX = 37;

   // feedback masks, bit i is stage i+1
   localparam logic [NSTG-1:0] REG_A_MASK = 10'h204;
   localparam logic [NSTG-1:0] REG_B_MASK = 10'h3A6;

   typedef struct packed {
      logic [TAP_W-1:0] a;
      logic [TAP_W-1:0] b;
   } tap_pair_t;

   function automatic logic code_in_range(input logic [CNUM_W-1:0] n);
      return (n >= CNUM_W'(CODE_MIN)) && (n <= CNUM_W'(CODE_MAX));
   endfunction

   function automatic tap_pair_t tap_lookup(input logic [CNUM_W-1:0] n);
      tap_pair_t r;
      case (n)
         6'd1:  r = {4'd2, 4'd6};
         6'd2:  r = {4'd3, 4'd7};
         6'd3:  r = {4'd4, 4'd8};
         6'd4:  r = {4'd5, 4'd9};
         6'd5:  r = {4'd1, 4'd9};
         6'd6:  r = {4'd2, 4'd10};
         6'd7:  r = {4'd1, 4'd8};
         6'd8:  r = {4'd2, 4'd9};
         6'd9:  r = {4'd3, 4'd10};
         6'd10: r = {4'd2, 4'd3};
         6'd11: r = {4'd3, 4'd4};
         6'd12: r = {4'd5, 4'd6};
         6'd13: r = {4'd6, 4'd7};
         6'd14: r = {4'd7, 4'd8};
         6'd15: r = {4'd8, 4'd9};
         6'd16: r = {4'd9, 4'd10};
         6'd17: r = {4'd1, 4'd4};
         6'd18: r = {4'd2, 4'd5};
         6'd19: r = {4'd3, 4'd6};
         6'd20: r = {4'd4, 4'd7};
         6'd21: r = {4'd5, 4'd8};
         6'd22: r = {4'd6, 4'd9};
         6'd23: r = {4'd1, 4'd3};
         6'd24: r = {4'd4, 4'd6};
         6'd25: r = {4'd5, 4'd7};
         6'd26: r = {4'd6, 4'd8};
         6'd27: r = {4'd7, 4'd9};
         6'd28: r = {4'd8, 4'd10};
         6'd29: r = {4'd1, 4'd6};
         6'd30: r = {4'd2, 4'd7};
         6'd31: r = {4'd3, 4'd8};
         6'd32: r = {4'd4, 4'd9};
         6'd33: r = {4'd5, 4'd10};
         6'd34: r = {4'd4, 4'd10};
         6'd35: r = {4'd1, 4'd7};
         6'd36: r = {4'd2, 4'd8};
         6'd37: r = {4'd4, 4'd10};
         default: r = '0;
      endcase
      return r;
   endfunction
endpackage

// File: rtl/gref_lfsr.sv
module gref_lfsr #(
   parameter int              NSTG    = 10,
   parameter logic [NSTG-1:0] FB_MASK = 10'h204
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            init,
   input  logic            adv,
   output logic [NSTG-1:0] state
);
   if (NSTG < 2) begin : g_bad_len
      $error("gref_lfsr: NSTG must be at least 2");
   end
   if (FB_MASK[NSTG-1] != 1'b1) begin : g_bad_mask
      $error("gref_lfsr: last stage must be in the feedback");
   end

   logic [NSTG-1:0] q;
   logic            fb;

   assign fb    = ^(q & FB_MASK);
   assign state = q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '1;
      else if (init) q <= '1;
      else if (adv)  q <= {q[NSTG-2:0], fb};
   end

   // R1: a register started from all ones never reaches the lock-up state
   a_r1_no_lockup: assert property (@(posedge clk) disable iff (!rst_n)
      q != '0);
endmodule

// File: rtl/gref_seq.sv
module gref_seq #(
   parameter int NPTS     = 4096,
   parameter int SPC      = 2,
   parameter int REPS     = 2,
   parameter int CODE_LEN = 1023,
   localparam int AW      = $clog2(NPTS),
   localparam int CW      = $clog2(CODE_LEN),
   localparam int PW      = (SPC > 1) ? $clog2(SPC) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          launch,
   output logic          run,
   output logic          done,
   output logic [AW-1:0] addr,
   output logic [PW-1:0] ph,
   output logic [CW-1:0] chip_idx,
   output logic          init,
   output logic          adv,
   output logic          in_data
);
   localparam int PERIOD   = CODE_LEN * SPC;
   localparam int DATA_END = PERIOD * REPS;
   localparam logic [AW-1:0] LAST = AW'(NPTS - 1);

   if (DATA_END > NPTS) begin : g_bad_fit
      $error("gref_seq: repeated code does not fit the frame");
   end
   if (SPC < 1 || REPS < 1) begin : g_bad_cnt
      $error("gref_seq: SPC and REPS must be positive");
   end

   logic          run_q, done_q, chip_end;
   logic [AW-1:0] addr_q;
   logic [PW-1:0] ph_q;
   logic [CW-1:0] chip_q;

   if (SPC == 1) begin : g_one_spc
      assign chip_end = 1'b1;
   end else begin : g_multi_spc
      assign chip_end = (ph_q == PW'(SPC - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         done_q <= 1'b0;
         addr_q <= '0;
         ph_q   <= '0;
         chip_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (!run_q) begin
            if (launch) begin
               run_q  <= 1'b1;
               addr_q <= '0;
               ph_q   <= '0;
               chip_q <= '0;
            end
         end else begin
            addr_q <= addr_q + 1'b1;
            if (addr_q == LAST) begin
               run_q  <= 1'b0;
               done_q <= 1'b1;
            end
            if (chip_end) begin
               ph_q   <= '0;
               chip_q <= (chip_q == CW'(CODE_LEN - 1)) ? '0 : chip_q + 1'b1;
            end else begin
               ph_q <= ph_q + 1'b1;
            end
         end
      end
   end

   assign run      = run_q;
   assign done     = done_q;
   assign addr     = addr_q;
   assign ph       = ph_q;
   assign chip_idx = chip_q;
   assign in_data  = int'(addr_q) < DATA_END;
   assign init     = launch && !run_q;
   assign adv      = run_q && chip_end && in_data;

   // R6: consecutive write addresses within a pass
   a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && $past(run_q)) |-> (addr_q == $past(addr_q) + 1'b1));
   // R7: pass ends with a done pulse right after the last address
   a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && addr_q == LAST) |=> (done_q && !run_q));
   // R7: done lasts one cycle
   a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
endmodule

// File: rtl/gref_fmt.sv
module gref_fmt #(
   parameter int DW = 8
) (
   input  logic          chip,
   input  logic          zero,
   output logic [DW-1:0] data
);
   if (DW < 2) begin : g_bad_dw
      $error("gref_fmt: sample needs a sign and a units bit");
   end

   logic [1:0] top2;
   assign top2 = chip ? 2'b11 : 2'b01;

   if (DW == 2) begin : g_no_frac
      assign data = zero ? '0 : top2;
   end else begin : g_frac
      assign data = zero ? '0 : {top2, {(DW-2){1'b0}}};
   end
endmodule

// File: rtl/gold_ref_gen.sv
module gold_ref_gen #(
   parameter int  NPTS = 4096,
   parameter int  SPC  = 2,
   parameter int  REPS = 2,
   parameter int  DW   = 8,
   localparam int AW   = $clog2(NPTS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [5:0]    code_num,
   input  logic          code_load,
   input  logic          start,
   output logic          wr_en,
   output logic [AW-1:0] wr_addr,
   output logic [DW-1:0] wr_data,
   output logic          busy,
   output logic          done,
   output logic          code_err
);
   import gref_pkg::*;

   localparam int CW       = $clog2(CODE_LEN);
   localparam int PW       = (SPC > 1) ? $clog2(SPC) : 1;
   localparam int DATA_END = CODE_LEN * SPC * REPS;

   if (CNUM_W != 6) begin : g_bad_cnum
      $error("gold_ref_gen: code number port is 6 bits");
   end

   tap_pair_t     taps_q;
   logic          code_ok_q, err_q;
   logic          run, in_data, init, adv, launch, chip_bit, b_bit;
   logic [AW-1:0] addr;
   logic [PW-1:0] ph;
   logic [CW-1:0] chip_idx;
   logic [NSTG-1:0] ra, rb, hit_a, hit_b;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         taps_q    <= '0;
         code_ok_q <= 1'b0;
         err_q     <= 1'b0;
      end else if (code_load && !run) begin
         taps_q    <= tap_lookup(code_num);
         code_ok_q <= code_in_range(code_num);
         err_q     <= !code_in_range(code_num);
      end
   end

   assign launch = start && code_ok_q;

   gref_seq #(.NPTS(NPTS), .SPC(SPC), .REPS(REPS), .CODE_LEN(CODE_LEN)) seq_i (
      .clk(clk), .rst_n(rst_n), .launch(launch), .run(run), .done(done),
      .addr(addr), .ph(ph), .chip_idx(chip_idx), .init(init), .adv(adv),
      .in_data(in_data)
   );

   gref_lfsr #(.NSTG(NSTG), .FB_MASK(REG_A_MASK)) reg_a_i (
      .clk(clk), .rst_n(rst_n), .init(init), .adv(adv), .state(ra)
   );

   gref_lfsr #(.NSTG(NSTG), .FB_MASK(REG_B_MASK)) reg_b_i (
      .clk(clk), .rst_n(rst_n), .init(init), .adv(adv), .state(rb)
   );

   for (genvar i = 0; i < NSTG; i++) begin : g_tap
      assign hit_a[i] = (taps_q.a == TAP_W'(i + 1)) & rb[i];
      assign hit_b[i] = (taps_q.b == TAP_W'(i + 1)) & rb[i];
   end

   assign b_bit    = (|hit_a) ^ (|hit_b);
   assign chip_bit = ra[NSTG-1] ^ b_bit;

   gref_fmt #(.DW(DW)) fmt_i (
      .chip(chip_bit), .zero(!in_data), .data(wr_data)
   );

   assign wr_en    = run;
   assign wr_addr  = addr;
   assign busy     = run;
   assign code_err = err_q;

   // R1: each code period begins with both registers all ones
   a_r1_period_start: assert property (@(posedge clk) disable iff (!rst_n)
      (run && in_data && chip_idx == '0 && ph == '0) |-> (ra == '1 && rb == '1));
   // R3: samples within one chip are equal
   a_r3_pair_equal: assert property (@(posedge clk) disable iff (!rst_n)
      (run && ph != '0) |-> (wr_data == $past(wr_data)));
   // R5: padding addresses carry zero
   a_r5_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && int'(wr_addr) >= DATA_END) |-> (wr_data == '0));
   // R8: flagged code cannot launch a pass
   a_r8_err_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !run) |=> !wr_en);
   // R9: code selection held while busy
   a_r9_taps_held: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run)) |-> $stable(taps_q));
endmodule

// File: tb/gold_ref_gen_tb_top.sv
`timescale 1ns/1ps
module gold_ref_gen_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] code_num = '0;
   logic       code_load = 1'b0;
   logic       start = 1'b0;
   logic       wr_en, busy, done, code_err;
   logic [11:0] wr_addr;
   logic [7:0]  wr_data;

   int n_chk = 0;
   int n_fail = 0;

   logic [7:0] cap  [0:4095];
   logic [7:0] prev [0:4095];
   bit         mdl  [0:1022];

   always #2.5 clk = ~clk;

   gold_ref_gen dut_i (
      .clk(clk), .rst_n(rst_n), .code_num(code_num), .code_load(code_load),
      .start(start), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .busy(busy), .done(done), .code_err(code_err)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic void gen_model(input int ta, input int tb);
      logic [9:0] a = '1;
      logic [9:0] b = '1;
      for (int k = 0; k < 1023; k++) begin
         logic fa, fbb;
         mdl[k] = a[9] ^ b[ta-1] ^ b[tb-1];
         fa  = a[2] ^ a[9];
         fbb = b[1] ^ b[2] ^ b[5] ^ b[7] ^ b[8] ^ b[9];
         a = {a[8:0], fa};
         b = {b[8:0], fbb};
      end
   endfunction

   task automatic load_code(input int n);
      @(negedge clk);
      code_num = 6'(n);
      code_load = 1'b1;
      @(negedge clk);
      code_load = 1'b0;
   endtask

   task automatic no_write_after_start(input string req);
      int seen = 0;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 6; i++) begin
         if (wr_en || busy) seen++;
         @(negedge clk);
      end
      chk(seen == 0, req, "writes after blocked start", seen, 0);
   endtask

   task automatic t_reset;
      chk(!wr_en && !busy && !done && !code_err, "R11", "outputs after reset",
          {wr_en, busy, done, code_err}, 0);
      no_write_after_start("R11");
   endtask

   task automatic t_invalid(input int n);
      load_code(n);
      chk(code_err == 1'b1, "R8", "error flag for bad code", code_err, 1);
      no_write_after_start("R8");
   endtask

   task automatic run_pass(input int code, input int ta, input int tb, input bit disturb);
      int bad_seq = 0, bad_pair = 0, bad_val = 0, bad_ch = 0, bad_cp = 0, bad_pad = 0;
      int extra = 0;
      gen_model(ta, tb);
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 4096; i++) begin
         if (!wr_en || int'(wr_addr) != i || !busy) bad_seq++;
         cap[i] = wr_data;
         if (disturb && i == 100) begin
            start = 1'b1; code_load = 1'b1; code_num = 6'd2;
         end else if (disturb && i == 101) begin
            start = 1'b0; code_load = 1'b0; code_num = 6'(code);
         end
         @(negedge clk);
      end
      chk(bad_seq == 0, "R6", "address/enable run errors", bad_seq, 0);
      chk(done && !busy && !wr_en, "R7", "done after last write",
          {done, busy, wr_en}, 3'b100);
      @(negedge clk);
      chk(!done, "R7", "done single cycle", done, 0);
      for (int i = 0; i < 4; i++) begin
         if (wr_en) extra++;
         @(negedge clk);
      end
      chk(extra == 0, disturb ? "R9" : "R6", "writes beyond 4096", extra, 0);
      for (int i = 0; i < 2046; i += 2) begin
         if (cap[i] != cap[i+1]) bad_pair++;
         if (cap[i] != 8'h40 && cap[i] != 8'hC0) bad_val++;
         if (cap[i] != (mdl[i/2] ? 8'hC0 : 8'h40)) bad_ch++;
      end
      for (int i = 0; i < 2046; i++) if (cap[i+2046] != cap[i]) bad_cp++;
      for (int i = 4092; i < 4096; i++) if (cap[i] != 8'h00) bad_pad++;
      chk(bad_pair == 0, "R3", "unequal sample pairs", bad_pair, 0);
      chk(bad_val == 0, "R2", "non +/-1 samples", bad_val, 0);
      chk(bad_ch == 0, disturb ? "R9" : "R1", "chip mismatches vs model", bad_ch, 0);
      chk(bad_cp == 0, "R4", "second period mismatches", bad_cp, 0);
      chk(bad_pad == 0, "R5", "nonzero pad samples", bad_pad, 0);
   endtask

   function automatic int frame_diff;
      int d = 0;
      for (int i = 0; i < 4096; i++) if (cap[i] != prev[i]) d++;
      return d;
   endfunction

   task automatic save_frame;
      for (int i = 0; i < 4096; i++) prev[i] = cap[i];
   endtask

   task automatic t_code1_literal;
      int first10 = 0;
      for (int k = 0; k < 10; k++) first10 = (first10 << 1) | (cap[2*k] == 8'hC0 ? 1 : 0);
      chk(first10 == 10'b1100100000, "R1", "code 1 first ten chips", first10, 10'b1100100000);
      chk(cap[0] == 8'hC0, "R2", "chip 1 encodes -1", cap[0], 8'hC0);
      chk(cap[4] == 8'h40, "R2", "chip 0 encodes +1", cap[4], 8'h40);
   endtask

   initial begin
      #(5.0 * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL R6 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_invalid(0);
      t_invalid(38);
      t_invalid(63);
      load_code(1);
      chk(code_err == 1'b0, "R8", "valid load clears flag", code_err, 0);
      run_pass(1, 2, 6, 1'b0);
      t_code1_literal();
      save_frame();
      run_pass(1, 2, 6, 1'b1);
      chk(frame_diff() == 0, "R9", "disturbed pass equals clean pass", frame_diff(), 0);
      run_pass(1, 2, 6, 1'b0);
      chk(frame_diff() == 0, "R9", "code kept after busy load", frame_diff(), 0);
      load_code(2);
      run_pass(2, 3, 7, 1'b0);
      chk(frame_diff() != 0, "R10", "code 2 differs from code 1", frame_diff() != 0, 1);
      load_code(5);
      run_pass(5, 1, 9, 1'b0);
      load_code(24);
      run_pass(24, 4, 6, 1'b0);
      load_code(34);
      run_pass(34, 4, 10, 1'b0);
      save_frame();
      load_code(37);
      run_pass(37, 4, 10, 1'b0);
      chk(frame_diff() == 0, "R10", "codes 34 and 37 identical", frame_diff(), 0);
      t_invalid(40);
      load_code(37);
      chk(code_err == 1'b0, "R8", "flag cleared by later valid load", code_err, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule